// File: doc/BRIEF.md
# Snoop-Unit Control Register Block

This block is the register window of a snoop control unit that serves a cluster of one to four processors. A host reaches it through a 256-byte window using a request channel with valid/ready handshakes. Each request carries a byte address, a write flag, a 32-bit data word and four byte strobes. The registers are 32-bit words, and the low two address bits select a byte inside a word. Narrow accesses drive the matching strobes, and their data sits on the matching byte lanes.

The block holds the following state and read values:
- A one-bit unit enable, which is also driven on a pin.
- A read-only configuration word, computed at elaboration from the processor count.
- A power-status word that software may write byte by byte.
- A cache-invalidate location that has no effect.
- Two address-filter locations that read as zero.

An access to any other location reads as zero and is ignored. Such an access also raises a one-cycle flag.

Reads return their data on a response channel one cycle after acceptance. A response is held until the host takes it. While a response is waiting and `rsp_ready` is low, `req_ready` is low, so at most one response is ever pending. Writes complete when they are accepted and produce no response.

Top module: `snoop_regif`

## Requirements
- R1: The control word sits at byte addresses 0x00–0x03. A write with strobe bit 0 set stores write-data bit 0. A write with strobe bit 0 clear leaves the stored bit unchanged. Bits 31:1 read as 0. Reset clears the bit. `scu_enable` shows the stored bit.
- R2: The configuration word sits at 0x04–0x07 and is read-only. Bits 7:4 hold a mask in which the lowest NUM_CPU bits are set. Bits 1:0 hold NUM_CPU−1. All other bits are 0. Writes to it change nothing. A NUM_CPU outside 1..4 stops elaboration.
- R3: The power-status word sits at 0x08–0x0B, and a write to any of those four addresses targets it. Only byte lanes whose strobe bit is set are written: lane k is data bits 8k+7:8k. A read returns the stored word.
- R4: Reset leaves the power-status word unchanged.
- R5: The invalidate location 0x0C–0x0F reads as 0. A write there changes no state.
- R6: The filter locations 0x40–0x43 and 0x44–0x47 read as 0 and ignore writes. Accesses to them do not raise `unsup_pulse`.
- R7: Every other address, including 0x50 and 0x54, reads as 0 and ignores writes. When such an access is accepted on a clock edge, `unsup_pulse` is high for the cycle after that edge. `unsup_pulse` is low in all other cycles.
- R8: After an accepted read, `rsp_valid` is high in the next cycle with the read data. `rsp_valid` and `rsp_rdata` stay unchanged while `rsp_ready` is low. An accepted write produces no response.
- R9: `req_ready` is low exactly when a response is pending and `rsp_ready` is low. Otherwise a request can be accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 8 | Byte address inside the window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, lane-aligned |
| req_strb | input | 4 | Byte-lane enables for writes |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Host takes the read data |
| rsp_rdata | output | 32 | Read data |
| scu_enable | output | 1 | Stored unit-enable bit |
| unsup_pulse | output | 1 | One-cycle flag for an access to an unsupported address |

## Verification
The bench builds the block with NUM_CPU = 3. With that value the presence mask is neither empty nor full (0x7) and the count field is neither 0 nor its maximum (2). A mask that is shifted, has the wrong length or has its bits reversed therefore gives a wrong configuration word, and so does an off-by-one count. The three response modes (always ready, a periodic stall pattern and a long stall) exercise the hold rule of R8 and the back-pressure rule of R9 with that same build.

// File: rtl/snoop_regif_pkg.sv
package snoop_regif_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LANES     = WORD_W / 8;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned IDX_W     = ADDR_W - 2;
  localparam int unsigned CPU_LIMIT = 4;

  // Word indices (byte address / 4) of the decoded locations
  localparam logic [IDX_W-1:0] IDX_CTRL   = 6'h00;
  localparam logic [IDX_W-1:0] IDX_CFG    = 6'h01;
  localparam logic [IDX_W-1:0] IDX_PWR    = 6'h02;
  localparam logic [IDX_W-1:0] IDX_INV    = 6'h03;
  localparam logic [IDX_W-1:0] IDX_FLT_LO = 6'h10;
  localparam logic [IDX_W-1:0] IDX_FLT_HI = 6'h11;

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_CFG,
    SEL_PWR,
    SEL_INV,
    SEL_FILT,
    SEL_NONE
  } reg_sel_e;

  // Presence mask in bits 7:4, count minus one in bits 1:0
  function automatic logic [WORD_W-1:0] cfg_word(input int unsigned n);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = 0; i < int'(CPU_LIMIT); i++) begin
      if (i < int'(n)) w[4+i] = 1'b1;
    end
    w[1:0] = 2'(n - 1);
    return w;
  endfunction

endpackage

// File: rtl/snoop_regif_decode.sv
module snoop_regif_decode
  import snoop_regif_pkg::*;
(
  input  logic [IDX_W-1:0] word_idx,
  output reg_sel_e         sel
);

  always_comb begin
    unique case (word_idx)
      IDX_CTRL:               sel = SEL_CTRL;
      IDX_CFG:                sel = SEL_CFG;
      IDX_PWR:                sel = SEL_PWR;
      IDX_INV:                sel = SEL_INV;
      IDX_FLT_LO, IDX_FLT_HI: sel = SEL_FILT;
      default:                sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/snoop_regif_regs.sv
module snoop_regif_regs
  import snoop_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  strb,
  output logic              ctrl_q,
  output logic [WORD_W-1:0] pwr_q
);

  // Enable bit: the only state touched by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   ctrl_q <= 1'b0;
    else if (wr_en && sel == SEL_CTRL && strb[0]) ctrl_q <= wdata[0];
  end

  // Power status: per-lane write, deliberately outside reset
  for (genvar g = 0; g < int'(LANES); g++) begin : g_pwr_lane
    always_ff @(posedge clk) begin
      if (wr_en && sel == SEL_PWR && strb[g])
        pwr_q[g*8 +: 8] <= wdata[g*8 +: 8];
    end
  end

endmodule

// File: rtl/snoop_regif_resp.sv
module snoop_regif_resp
  import snoop_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_acc,
  input  reg_sel_e          sel,
  input  logic              ctrl_q,
  input  logic [WORD_W-1:0] pwr_q,
  input  logic [WORD_W-1:0] cfg,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata
);

  logic [WORD_W-1:0] rd_value;

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_value = {{(WORD_W-1){1'b0}}, ctrl_q};
      SEL_CFG:  rd_value = cfg;
      SEL_PWR:  rd_value = pwr_q;
      default:  rd_value = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_value;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/snoop_regif.sv
module snoop_regif
  import snoop_regif_pkg::*;
#(
  parameter int unsigned NUM_CPU = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_strb,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              scu_enable,
  output logic              unsup_pulse
);

  if ((NUM_CPU < 1) || (NUM_CPU > CPU_LIMIT)) begin : g_bad_cpu_count
    $error("snoop_regif: NUM_CPU must lie in 1..4");
  end

  localparam logic [WORD_W-1:0] CFG_VALUE = cfg_word(NUM_CPU);

  reg_sel_e          sel;
  logic              acc;
  logic              rd_acc;
  logic              wr_en;
  logic              ctrl_q;
  logic [WORD_W-1:0] pwr_q;
  logic              unused_addr_lsb;

  // Byte offset inside a word plays no part in decode
  assign unused_addr_lsb = ^req_addr[1:0];

  // Single pending response: stall while it waits for the host
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign rd_acc    = acc && !req_write;
  assign wr_en     = acc && req_write;

  snoop_regif_decode u_decode (
    .word_idx (req_addr[ADDR_W-1:2]),
    .sel      (sel)
  );

  snoop_regif_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .sel    (sel),
    .wdata  (req_wdata),
    .strb   (req_strb),
    .ctrl_q (ctrl_q),
    .pwr_q  (pwr_q)
  );

  snoop_regif_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_acc    (rd_acc),
    .sel       (sel),
    .ctrl_q    (ctrl_q),
    .pwr_q     (pwr_q),
    .cfg       (CFG_VALUE),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unsup_pulse <= 1'b0;
    else        unsup_pulse <= acc && (sel == SEL_NONE);
  end

  assign scu_enable = ctrl_q;

endmodule

// File: rtl/snoop_regif_chk.sv
module snoop_regif_chk #(
  parameter int unsigned NUM_CPU = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [7:0]  req_addr,
  input logic        req_write,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        scu_enable,
  input logic        unsup_pulse
);

  function automatic logic [31:0] ref_cfg();
    logic [31:0] v;
    v = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < int'(NUM_CPU)) v[4+k] = 1'b1;
    end
    v[1:0] = 2'(NUM_CPU - 1);
    return v;
  endfunction

  logic        acc_rd, acc_wr;
  logic        hit_cfg, hit_zero;
  logic [31:0] cfg_ref;

  assign acc_rd   = req_valid && req_ready && !req_write;
  assign acc_wr   = req_valid && req_ready && req_write;
  assign cfg_ref  = ref_cfg();
  assign hit_cfg  = (req_addr >= 8'h04) && (req_addr <= 8'h07);
  assign hit_zero = ((req_addr >= 8'h0C) && (req_addr <= 8'h0F)) ||
                    ((req_addr >= 8'h40) && (req_addr <= 8'h47));

  p_enable_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !scu_enable);

  p_enable_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable(scu_enable));

  p_cfg_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && hit_cfg) |=> (rsp_valid && rsp_rdata == cfg_ref));

  p_zero_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && hit_zero) |=> (rsp_valid && rsp_rdata == 32'h0));

  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_pulse |-> $past(req_valid && req_ready));

  p_read_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid);

  p_write_no_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> !rsp_valid);

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

endmodule

bind snoop_regif snoop_regif_chk #(.NUM_CPU(NUM_CPU)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .req_write   (req_write),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .scu_enable  (scu_enable),
  .unsup_pulse (unsup_pulse)
);

// File: tb/snoop_regif_tb_top.sv
`timescale 1ns/1ps
module snoop_regif_tb_top;

  localparam int unsigned N_CPU = 3;
  localparam real         TCLK  = 8.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_strb = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        scu_enable;
  logic        unsup_pulse;

  int checks = 0;
  int errors = 0;
  int rr_mode = 0;   // 0 always ready, 1 periodic stall, 2 hold low
  int cyc = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(TCLK/2.0) clk = ~clk;

  snoop_regif #(.NUM_CPU(N_CPU)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_strb(req_strb),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .scu_enable(scu_enable), .unsup_pulse(unsup_pulse)
  );

  function automatic logic [31:0] exp_cfg();
    logic [31:0] v = '0;
    for (int k = 0; k < int'(N_CPU); k++) v[4+k] = 1'b1;
    v[1:0] = 2'(N_CPU - 1);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Response-side ready pattern, changed away from both clock edges
  always @(posedge clk) begin
    #2;
    cyc <= cyc + 1;
    case (rr_mode)
      1:       rsp_ready <= (cyc % 3) != 0;
      2:       rsp_ready <= 1'b0;
      default: rsp_ready <= 1'b1;
    endcase
  end

  // Monitor: a handshake seen at a falling edge completes at the next rising edge
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected response", rsp_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_rdata == e, t, rsp_rdata, e);
      end
    end
  end

  task automatic access(input logic [7:0] a, input bit wr, input logic [31:0] d,
                        input logic [3:0] s, input logic [31:0] exp,
                        input bit exp_unsup, input string tag);
    @(negedge clk);
    req_addr = a; req_write = wr; req_wdata = d; req_strb = s; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    if (!wr) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(unsup_pulse == exp_unsup, "R7 pulse after accept", {31'b0, unsup_pulse},
          {31'b0, exp_unsup});
    @(negedge clk);
    check(unsup_pulse == 1'b0, "R7 pulse one cycle", {31'b0, unsup_pulse}, 32'h0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    access(a, 1'b0, 32'h0, 4'h0, exp, 1'b0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    access(a, 1'b1, d, s, 32'h0, 1'b0, "");
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R8 all responses returned", exp_q.size(), 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(TCLK * 100000);
    check(1'b0, "watchdog", 32'h0, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check(scu_enable == 1'b0, "R1 enable after reset", {31'b0, scu_enable}, 32'h0);
    check(rsp_valid == 1'b0, "R8 no response after reset", {31'b0, rsp_valid}, 32'h0);
    check(req_ready == 1'b1, "R9 ready after reset", {31'b0, req_ready}, 32'h1);
    check(unsup_pulse == 1'b0, "R7 pulse after reset", {31'b0, unsup_pulse}, 32'h0);

    // R1 control bit
    rd(8'h00, 32'h0, "R1 control reads 0");
    wr(8'h00, 32'hFFFF_FFFF, 4'hF);
    check(scu_enable == 1'b1, "R1 enable set", {31'b0, scu_enable}, 32'h1);
    rd(8'h00, 32'h1, "R1 only bit 0 stored");
    wr(8'h00, 32'h0, 4'b1110);
    check(scu_enable == 1'b1, "R1 lane 0 strobe off keeps bit", {31'b0, scu_enable}, 32'h1);
    wr(8'h00, 32'h0, 4'b0001);
    check(scu_enable == 1'b0, "R1 enable cleared", {31'b0, scu_enable}, 32'h0);

    // R2 configuration word
    rd(8'h04, exp_cfg(), "R2 config value");
    wr(8'h04, 32'h0, 4'hF);
    rd(8'h04, exp_cfg(), "R2 config ignores write");
    rd(8'h05, exp_cfg(), "R2 config via byte address");

    // R3 power status, lane writes
    wr(8'h08, 32'h1122_3344, 4'hF);
    rd(8'h08, 32'h1122_3344, "R3 full write");
    wr(8'h0B, 32'hAA00_0000, 4'b1000);
    rd(8'h08, 32'hAA22_3344, "R3 lane 3 via 0x0B");
    wr(8'h09, 32'h0000_BB00, 4'b0010);
    rd(8'h0A, 32'hAA22_BB44, "R3 lane 1 via 0x09");

    // R5 invalidate location
    wr(8'h00, 32'h1, 4'h1);
    wr(8'h0C, 32'hFFFF_FFFF, 4'hF);
    rd(8'h0C, 32'h0, "R5 invalidate reads 0");
    rd(8'h08, 32'hAA22_BB44, "R5 power unchanged");
    check(scu_enable == 1'b1, "R5 enable unchanged", {31'b0, scu_enable}, 32'h1);

    // R6 filter locations
    wr(8'h40, 32'hFFFF_FFFF, 4'hF);
    wr(8'h44, 32'hFFFF_FFFF, 4'hF);
    rd(8'h40, 32'h0, "R6 filter start reads 0");
    rd(8'h44, 32'h0, "R6 filter end reads 0");

    // R7 unsupported locations
    access(8'h50, 1'b1, 32'hFFFF_FFFF, 4'hF, 32'h0, 1'b1, "");
    access(8'h54, 1'b1, 32'hFFFF_FFFF, 4'hF, 32'h0, 1'b1, "");
    access(8'h50, 1'b0, 32'h0, 4'h0, 32'h0, 1'b1, "R7 0x50 reads 0");
    access(8'h80, 1'b0, 32'h0, 4'h0, 32'h0, 1'b1, "R7 0x80 reads 0");
    access(8'hFC, 1'b1, 32'h0, 4'hF, 32'h0, 1'b1, "");
    access(8'h10, 1'b1, 32'h0, 4'hF, 32'h0, 1'b1, "");
    rd(8'h08, 32'hAA22_BB44, "R7 power unchanged");
    rd(8'h00, 32'h1, "R7 control unchanged");

    // R4 power status survives reset, control does not
    wr(8'h08, 32'hA5A5_5A5A, 4'hF);
    drain();
    do_reset();
    @(negedge clk);
    check(scu_enable == 1'b0, "R1 reset clears enable", {31'b0, scu_enable}, 32'h0);
    rd(8'h08, 32'hA5A5_5A5A, "R4 power kept over reset");
    rd(8'h00, 32'h0, "R1 control after reset");
    drain();

    // R8/R9 long stall
    rr_mode = 2;
    repeat (2) @(negedge clk);
    rd(8'h08, 32'hA5A5_5A5A, "R8 held response");
    check(rsp_valid == 1'b1, "R8 response pending", {31'b0, rsp_valid}, 32'h1);
    check(req_ready == 1'b0, "R9 stalled", {31'b0, req_ready}, 32'h0);
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b1 && rsp_rdata == 32'hA5A5_5A5A, "R8 held stable",
          rsp_rdata, 32'hA5A5_5A5A);
    check(req_ready == 1'b0, "R9 still stalled", {31'b0, req_ready}, 32'h0);
    rr_mode = 0;
    drain();
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready after drain", {31'b0, req_ready}, 32'h1);

    // R8/R9 periodic stall with mixed traffic
    rr_mode = 1;
    for (int i = 0; i < 6; i++) begin
      wr(8'h08, 32'h0101_0101 * (i + 1), 4'hF);
      rd(8'h08, 32'h0101_0101 * (i + 1), "R9 mixed traffic power");
      rd(8'h04, exp_cfg(), "R9 mixed traffic config");
      rd(8'h00, 32'h0, "R9 mixed traffic control");
    end
    rr_mode = 0;
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule